// File: doc/BRIEF.md
# Per-Hart Timer and Inter-Processor Interrupt Unit

This block gives each hart in a cluster two interrupt lines. One is a timer interrupt and the other is a software (inter-processor) interrupt. A 64-bit time value starts at zero after reset. It advances by a fixed step once every fixed number of clock cycles. Each hart owns a 64-bit compare register. Its timer line is raised while that compare value is strictly below the current time. Each hart also owns a one-bit software-interrupt flag. Any hart can set or clear another hart's flag by writing to the register of the target hart.

Software reaches the block over a plain 32-bit register bus. A write takes effect at the clock edge that samples it. Read data appears on the cycle after the request. Every 64-bit quantity is split into two word-wide halves.

The address map has three regions, each at a fixed address:
- The software flags are at a stride of 4 bytes from offset 0x0000.
- The compare registers are at a stride of 8 bytes from 0x4000.
- The time value is at 0xBFF8 and 0xBFFC.

Top module: `hart_timer_ipi`

## Requirements
- R1: After reset the time value is zero. It grows by TIME_STEP on every TICK_INTERVAL-th clock edge after reset and is otherwise constant.
- R2: A read at 0xBFF8 returns time bits 31:0 and a read at 0xBFFC returns bits 63:32. Writes to either address leave the time unchanged.
- R3: The software flag of hart h sits at offset 4·h. A write of exactly 0x00000001 sets it, and a write of any other value clears it. Flags of other harts are not touched. A read returns the flag in bit 0, with zeros above.
- R4: The compare register of hart h has bits 31:0 at 0x4000+8·h and bits 63:32 at 0x4000+8·h+4. Both halves can be read and written, and writing one half leaves the other unchanged.
- R5: Compare registers reset to all ones, and every interrupt output is low after reset.
- R6: timer_irq[h] is high in a cycle exactly when, one clock earlier, compare[h] was strictly less than time. Equal values do not raise it.
- R7: soft_irq[h] shows the flag of hart h and changes at the clock edge that samples the write.
- R8: bus_rdata resets to zero. It takes the addressed value at the edge that samples a read, using the state before that edge, and holds it until the next read.
- R9: Offsets outside the three regions, including offsets that are not word-aligned, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Bus request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| timer_irq | output | NUM_HARTS | Timer interrupt per hart |
| soft_irq | output | NUM_HARTS | Software interrupt per hart |

## Verification
The bench builds the block with three harts, a tick interval of 5 and a step of 7. Three harts do not fill a power-of-two hart index, so decoded hart numbers that exist only in the index width fall outside the regions and must read as zero. The short interval makes the time cross freshly written compare values hundreds of times within a few thousand cycles. Those crossings exercise the strict-less-than rule in both directions, including the cycle where compare equals time.

// File: rtl/htimer_pkg.sv
package htimer_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADDR_W = 16;

    localparam logic [ADDR_W-1:0] SIP_BASE    = 16'h0000;
    localparam logic [ADDR_W-1:0] CMP_BASE    = 16'h4000;
    localparam logic [ADDR_W-1:0] TIME_LO_OFS = 16'hBFF8;
    localparam logic [ADDR_W-1:0] TIME_HI_OFS = 16'hBFFC;

    typedef logic [63:0] tval_t;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_SIP,
        RG_CMP_LO,
        RG_CMP_HI,
        RG_TIME_LO,
        RG_TIME_HI
    } region_e;

    typedef struct packed {
        tval_t cmp;
        logic  sip;
        logic  tip;
    } hart_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } rsp_state_t;

endpackage

// File: rtl/htimer_decode.sv
module htimer_decode
    import htimer_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    localparam int unsigned HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [HART_W-1:0] hart
);
    localparam logic [ADDR_W-1:0] SIP_SPAN = ADDR_W'(4 * NUM_HARTS);
    localparam logic [ADDR_W-1:0] CMP_SPAN = ADDR_W'(8 * NUM_HARTS);

    logic [ADDR_W-1:0] sip_off;
    logic [ADDR_W-1:0] cmp_off;

    always_comb begin
        sip_off = addr - SIP_BASE;
        cmp_off = addr - CMP_BASE;
        region  = RG_NONE;
        hart    = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr >= SIP_BASE && sip_off < SIP_SPAN) begin
                region = RG_SIP;
                hart   = HART_W'(sip_off >> 2);
            end else if (addr >= CMP_BASE && cmp_off < CMP_SPAN) begin
                region = cmp_off[2] ? RG_CMP_HI : RG_CMP_LO;
                hart   = HART_W'(cmp_off >> 3);
            end else if (addr == TIME_LO_OFS) begin
                region = RG_TIME_LO;
            end else if (addr == TIME_HI_OFS) begin
                region = RG_TIME_HI;
            end
        end
    end

endmodule

// File: rtl/htimer_timebase.sv
module htimer_timebase
    import htimer_pkg::*;
#(
    parameter int unsigned TICK_INTERVAL = 100,
    parameter int unsigned TIME_STEP     = 10,
    localparam int unsigned CNT_W = (TICK_INTERVAL > 1) ? $clog2(TICK_INTERVAL) : 1
) (
    input  logic  clk,
    input  logic  rst,
    output tval_t now
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_INTERVAL - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        tval_t            now;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CNT_LAST) begin
            st_d.cnt = '0;
            st_d.now = st_q.now + tval_t'(TIME_STEP);
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign now = st_q.now;

endmodule

// File: rtl/htimer_hart_slot.sv
module htimer_hart_slot
    import htimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sip,
    input  logic              wr_cmp_lo,
    input  logic              wr_cmp_hi,
    input  logic [WORD_W-1:0] wdata,
    input  tval_t             now,
    output tval_t             cmp,
    output logic              sip,
    output logic              tip
);
    hart_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_sip) begin
            st_d.sip = (wdata == WORD_W'(1));
        end
        if (wr_cmp_lo) begin
            st_d.cmp[31:0] = wdata;
        end
        if (wr_cmp_hi) begin
            st_d.cmp[63:32] = wdata;
        end
        st_d.tip = (st_q.cmp < now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cmp <= '1;
            st_q.sip <= 1'b0;
            st_q.tip <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmp = st_q.cmp;
    assign sip = st_q.sip;
    assign tip = st_q.tip;

endmodule

// File: rtl/hart_timer_ipi.sv
module hart_timer_ipi
    import htimer_pkg::*;
#(
    parameter int unsigned NUM_HARTS     = 4,
    parameter int unsigned TICK_INTERVAL = 100,
    parameter int unsigned TIME_STEP     = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic [NUM_HARTS-1:0] timer_irq,
    output logic [NUM_HARTS-1:0] soft_irq
);
    localparam int unsigned HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    region_e                     dec_region;
    logic [HART_W-1:0]           dec_hart;
    tval_t                       time_now;
    logic [NUM_HARTS-1:0][63:0]  cmp_all;
    logic                        wr_req;
    logic [WORD_W-1:0]           rd_word;
    rsp_state_t                  rsp_d, rsp_q;

    assign wr_req = bus_valid && bus_write;

    htimer_decode #(
        .NUM_HARTS(NUM_HARTS)
    ) decode_i (
        .addr  (bus_addr),
        .region(dec_region),
        .hart  (dec_hart)
    );

    htimer_timebase #(
        .TICK_INTERVAL(TICK_INTERVAL),
        .TIME_STEP    (TIME_STEP)
    ) timebase_i (
        .clk(clk),
        .rst(rst),
        .now(time_now)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        logic hit;
        assign hit = wr_req && (dec_hart == HART_W'(h));

        htimer_hart_slot slot_i (
            .clk      (clk),
            .rst      (rst),
            .wr_sip   (hit && (dec_region == RG_SIP)),
            .wr_cmp_lo(hit && (dec_region == RG_CMP_LO)),
            .wr_cmp_hi(hit && (dec_region == RG_CMP_HI)),
            .wdata    (bus_wdata),
            .now      (time_now),
            .cmp      (cmp_all[h]),
            .sip      (soft_irq[h]),
            .tip      (timer_irq[h])
        );
    end

    always_comb begin
        rd_word = '0;
        unique case (dec_region)
            RG_SIP:     rd_word = {{(WORD_W-1){1'b0}}, soft_irq[dec_hart]};
            RG_CMP_LO:  rd_word = cmp_all[dec_hart][31:0];
            RG_CMP_HI:  rd_word = cmp_all[dec_hart][63:32];
            RG_TIME_LO: rd_word = time_now[31:0];
            RG_TIME_HI: rd_word = time_now[63:32];
            default:    rd_word = '0;
        endcase
        rsp_d = rsp_q;
        if (bus_valid && !bus_write) begin
            rsp_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign bus_rdata = rsp_q.rdata;

endmodule

// File: rtl/htimer_checker.sv
module htimer_checker
    import htimer_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned TIME_STEP = 10
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       bus_valid,
    input logic                       bus_write,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [WORD_W-1:0]          bus_rdata,
    input logic [NUM_HARTS-1:0]       timer_irq,
    input logic [NUM_HARTS-1:0]       soft_irq,
    input tval_t                      now,
    input logic [NUM_HARTS-1:0][63:0] cmp_all
);

    // R1: time either holds or moves by exactly one step
    p_time_step_r1: assert property (@(posedge clk) disable iff (rst)
        !$stable(now) |-> (now == $past(now) + tval_t'(TIME_STEP)));

    // R5: first cycle out of reset has no interrupt raised
    p_quiet_after_reset_r5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (timer_irq == '0 && soft_irq == '0));

    // R8: read data only moves after a read request
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_valid && !bus_write) |-> $stable(bus_rdata));

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_chk
        // R6: timer line follows a strict compare one cycle later
        p_tip_strict_r6: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (timer_irq[h] == ($past(cmp_all[h]) < $past(now))));

        // R3: a flag moves only after a write to its own offset
        p_sip_own_write_r3: assert property (@(posedge clk) disable iff (rst)
            (soft_irq[h] != $past(soft_irq[h])) |->
                $past(bus_valid && bus_write && bus_addr == ADDR_W'(4 * h)));

        // R4: low half changes only via its own address
        p_cmp_lo_write_r4: assert property (@(posedge clk) disable iff (rst)
            (cmp_all[h][31:0] != $past(cmp_all[h][31:0])) |->
                $past(bus_valid && bus_write && bus_addr == ADDR_W'(16'h4000 + 8 * h)));

        // R4: high half changes only via its own address
        p_cmp_hi_write_r4: assert property (@(posedge clk) disable iff (rst)
            (cmp_all[h][63:32] != $past(cmp_all[h][63:32])) |->
                $past(bus_valid && bus_write && bus_addr == ADDR_W'(16'h4000 + 8 * h + 4)));
    end

endmodule

bind hart_timer_ipi htimer_checker #(
    .NUM_HARTS(NUM_HARTS),
    .TIME_STEP(TIME_STEP)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .timer_irq(timer_irq),
    .soft_irq (soft_irq),
    .now      (time_now),
    .cmp_all  (cmp_all)
);

// File: tb/hart_timer_ipi_tb_top.sv
`timescale 1ns/1ps
module hart_timer_ipi_tb_top;
    localparam int NH   = 3;
    localparam int TICK = 5;
    localparam int STEP = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [15:0]   bus_addr  = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NH-1:0] timer_irq;
    logic [NH-1:0] soft_irq;

    int nvec = 0;
    int nerr = 0;
    bit run_chk = 1'b0;

    always #4 clk = ~clk;

    hart_timer_ipi #(
        .NUM_HARTS(NH),
        .TICK_INTERVAL(TICK),
        .TIME_STEP(STEP)
    ) dut_i (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .timer_irq(timer_irq), .soft_irq(soft_irq)
    );

    // reference state built from the requirements
    logic [63:0]   m_time;
    int            m_cnt;
    logic [63:0]   m_cmp [NH];
    logic [NH-1:0] m_sip;
    logic [NH-1:0] m_tip;

    always @(posedge clk) begin
        if (rst) begin
            m_time <= '0;
            m_cnt  <= 0;
            m_sip  <= '0;
            m_tip  <= '0;
            for (int h = 0; h < NH; h++) m_cmp[h] <= '1;
        end else begin
            if (m_cnt == TICK - 1) begin
                m_cnt  <= 0;
                m_time <= m_time + 64'(STEP);
            end else begin
                m_cnt <= m_cnt + 1;
            end
            for (int h = 0; h < NH; h++) begin
                m_tip[h] <= (m_cmp[h] < m_time);
                if (bus_valid && bus_write) begin
                    if (bus_addr == 16'(4*h)) m_sip[h] <= (bus_wdata == 32'd1);
                    if (bus_addr == 16'(16'h4000 + 8*h)) m_cmp[h][31:0] <= bus_wdata;
                    if (bus_addr == 16'(16'h4000 + 8*h + 4)) m_cmp[h][63:32] <= bus_wdata;
                end
            end
        end
    end

    function automatic logic [31:0] exp_read(input logic [15:0] a);
        logic [31:0] v;
        v = '0;
        if (a == 16'hBFF8) v = m_time[31:0];
        if (a == 16'hBFFC) v = m_time[63:32];
        for (int h = 0; h < NH; h++) begin
            if (a == 16'(4*h)) v = {31'b0, m_sip[h]};
            if (a == 16'(16'h4000 + 8*h)) v = m_cmp[h][31:0];
            if (a == 16'(16'h4000 + 8*h + 4)) v = m_cmp[h][63:32];
        end
        return v;
    endfunction

    function automatic string req_tag(input logic [15:0] a);
        if (a == 16'hBFF8 || a == 16'hBFFC) return "R2/R1";
        if (a < 16'(4*NH) && a[1:0] == 2'b00) return "R3";
        if (a >= 16'h4000 && a < 16'(16'h4000 + 8*NH) && a[1:0] == 2'b00) return "R4";
        return "R9";
    endfunction

    function automatic logic [15:0] rand_mapped();
        int unsigned s = $urandom % 6;
        int unsigned h = $urandom % NH;
        case (s)
            0, 1: return 16'(4*h);
            2:    return 16'(16'h4000 + 8*h);
            3:    return 16'(16'h4000 + 8*h + 4);
            4:    return 16'hBFF8;
            default: return 16'hBFFC;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // continuous per-cycle output checks, sampled on the falling edge
    always @(negedge clk) begin
        if (run_chk) begin
            check("R6 timer_irq", 64'(timer_irq), 64'(m_tip));
            check("R7 soft_irq", 64'(soft_irq), 64'(m_sip));
        end
    end

    task automatic do_write(input logic [15:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a);
        logic [31:0] e;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        e = exp_read(a);
        @(negedge clk);
        bus_valid = 1'b0;
        check({req_tag(a), " R8 read"}, 64'(bus_rdata), 64'(e));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] held;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // reset state (R5, R8)
        check("R5 timer_irq after reset", 64'(timer_irq), 64'h0);
        check("R5 soft_irq after reset", 64'(soft_irq), 64'h0);
        check("R8 rdata after reset", 64'(bus_rdata), 64'h0);
        run_chk = 1'b1;
        for (int h = 0; h < NH; h++) do_read(16'(16'h4000 + 8*h + 4));
        do_read(16'h4008);

        // R1: time advances only in steps
        do_read(16'hBFF8);
        idle(3*TICK);
        do_read(16'hBFF8);
        do_read(16'hBFFC);

        // R8: hold without a new read
        held = bus_rdata;
        idle(3);
        check("R8 rdata hold", 64'(bus_rdata), 64'(held));
        do_write(16'h0004, 32'h1);
        check("R8 rdata hold across write", 64'(bus_rdata), 64'(held));

        // R3: exact-one rule, isolation
        do_write(16'h0000, 32'h1);
        do_write(16'h0008, 32'h3);
        do_read(16'h0000); do_read(16'h0004); do_read(16'h0008);
        do_write(16'h0004, 32'h2);
        do_read(16'h0004);
        do_write(16'h0008, 32'h8000_0001);
        do_read(16'h0008);

        // R4: half write preserves other half
        do_write(16'h4010, 32'hDEAD_BEEF);
        do_read(16'h4010); do_read(16'h4014);
        do_write(16'h4014, 32'h0);
        do_read(16'h4010); do_read(16'h4014);

        // R6: compare just ahead of time, watch the crossing and equality
        do_write(16'h4004, 32'h0);
        do_write(16'h4000, m_time[31:0] + 32'(2*STEP));
        idle(4*TICK);
        do_write(16'h4000, m_time[31:0]);
        idle(2);

        // R9 and R2: ignored writes, zero reads
        do_write(16'h000C, 32'h1);
        do_write(16'h4002, 32'h1234);
        do_write(16'h4018, 32'h5555);
        do_write(16'hBFF8, 32'hFFFF_FFFF);
        do_write(16'hBFFC, 32'hFFFF_FFFF);
        do_read(16'h000C); do_read(16'h4002); do_read(16'h4018);
        do_read(16'h0001); do_read(16'hBFF4); do_read(16'hFFFC);
        for (int h = 0; h < NH; h++) begin
            do_read(16'(4*h));
            do_read(16'(16'h4000 + 8*h));
            do_read(16'(16'h4000 + 8*h + 4));
        end
        do_read(16'hBFF8); do_read(16'hBFFC);

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            int unsigned op = $urandom % 8;
            int unsigned h  = $urandom % NH;
            case (op)
                0, 1: do_read(rand_mapped());
                2:    do_read(16'($urandom));
                3:    do_write(16'(4*h), ($urandom % 2 == 0) ? 32'h1 : $urandom % 4);
                4:    do_write(16'(16'h4000 + 8*h), m_time[31:0] + ($urandom % 60) - 32'd20);
                5:    do_write(16'(16'h4000 + 8*h + 4), ($urandom % 6 == 0) ? 32'h1 : 32'h0);
                6:    do_write(16'($urandom), $urandom);
                default: idle(1 + $urandom % 4);
            endcase
        end
        idle(3);
        run_chk = 1'b0;
        finish_run();
    end

endmodule